// File: doc/BRIEF.md
# Error Alert Bundler with Differential Signalling

This block gathers the internal error flags of one peripheral into two alert classes: a recoverable alert and a fatal alert. Each class leaves the block as a complementary wire pair that an external alert handler answers with a complementary acknowledge pair. A single stuck wire therefore shows up as an illegal code instead of hiding or faking an alert. A recoverable alert produces one send for every new assertion of its bundled condition. A fatal alert latches and sends over and over until reset.

Two cause registers record which source fired. Software clears the recoverable cause bits by writing ones. The fatal cause bits only clear on reset. A test strobe with one bit per alert class injects an alert without touching any cause bit. If an acknowledge pair ever carries two equal values, an integrity fault is recorded in a dedicated fatal cause bit, and that fault raises the fatal alert.

Top module: `err_alert_bundler`

## Requirements
- R1: After reset, and whenever no alert is being signalled, each alert pair rests at p=0, n=1. Both cause registers read zero after reset.
- R2: To signal, a pair switches to p=1, n=0 and holds there until its acknowledge pair reads p=1, n=0 at a clock edge. It then returns to p=0, n=1. No new send starts until the acknowledge pair is back at p=0, n=1.
- R3: The recoverable alert sends exactly one event for each rising edge of the OR of `rec_err_i`. A condition that stays high produces no further sends.
- R4: A recoverable trigger that arrives while a recoverable handshake is in progress is held pending and sent once after that handshake. Any number of such triggers during one handshake merge into a single extra send.
- R5: Once any fatal source, the fatal test bit or an integrity fault is seen, the fatal alert sends back-to-back handshakes until reset, even after the source drops.
- R6: A cycle with `test_wr_i`=1 triggers the recoverable alert when `test_bits_i[0]`=1 and the fatal alert when `test_bits_i[1]`=1, exactly as a real event would. It sets no cause bit.
- R7: `rec_cause_o[i]` is set while `rec_err_i[i]` is high. A cycle with `clr_wr_i`=1 clears every bit whose `clr_bits_i` bit is 1, except that a source that is still high keeps its bit set.
- R8: `fat_cause_o[i]` for i < NUM_FAT is set when `fat_err_i[i]` is high. No fatal cause bit ever falls except through reset, and `clr_wr_i` has no effect on them.
- R9: If either acknowledge pair shows equal values at a clock edge, `fat_cause_o[NUM_FAT]` is set on that edge and the fatal alert starts as in R5.
- R10: `rst_ni` is active-low and asynchronous. Asserting it returns both pairs to p=0, n=1 at once and clears all cause bits and the fatal latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rec_err_i | input | NUM_REC | Active-high recoverable error sources |
| fat_err_i | input | NUM_FAT | Active-high fatal error sources |
| test_wr_i | input | 1 | Strobe for a write to the alert test bits |
| test_bits_i | input | 2 | Test data: bit 0 recoverable, bit 1 fatal |
| clr_wr_i | input | 1 | Strobe for a write-one-to-clear of recoverable causes |
| clr_bits_i | input | NUM_REC | Recoverable cause bits to clear |
| rec_cause_o | output | NUM_REC | Recoverable cause bits |
| fat_cause_o | output | NUM_FAT+1 | Fatal cause bits; top bit is the acknowledge integrity fault |
| rec_alert_p_o | output | 1 | Recoverable alert, true wire |
| rec_alert_n_o | output | 1 | Recoverable alert, complement wire |
| rec_ack_p_i | input | 1 | Recoverable acknowledge, true wire |
| rec_ack_n_i | input | 1 | Recoverable acknowledge, complement wire |
| fat_alert_p_o | output | 1 | Fatal alert, true wire |
| fat_alert_n_o | output | 1 | Fatal alert, complement wire |
| fat_ack_p_i | input | 1 | Fatal acknowledge, true wire |
| fat_ack_n_i | input | 1 | Fatal acknowledge, complement wire |

## Verification
The hardest situation to reach is a recoverable trigger landing while a handshake is in flight, since a prompt handler closes the window within a few cycles. The bench's handler model answers after a programmable delay. Stretching that delay keeps the pair in its signalling phase while several source pulses arrive, which shows whether they merge into a single pending send. The integrity fault is reached by forcing both acknowledge wires high for one cycle on top of the handler model.

// File: rtl/alert_bndl_pkg.sv
package alert_bndl_pkg;
  localparam int NUM_ALERTS = 2;
  localparam int ALERT_REC  = 0;
  localparam int ALERT_FAT  = 1;

  typedef enum logic [1:0] {
    PT_IDLE  = 2'd0,
    PT_SEND  = 2'd1,
    PT_DRAIN = 2'd2
  } pair_st_e;
endpackage

// File: rtl/alert_pair_tx.sv
// One differential alert sender with a four-phase acknowledge handshake.
module alert_pair_tx
  import alert_bndl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,     // one-shot request
  input  logic hold_i,     // repeat sends while high
  input  logic ack_p_i,
  input  logic ack_n_i,
  output logic alert_p_o,
  output logic alert_n_o,
  output logic ack_bad_o
);
  pair_st_e st_q, st_d;
  logic     pend_q, pend_d;
  logic     ack_hi, ack_lo;

  assign ack_hi    = ack_p_i & ~ack_n_i;
  assign ack_lo    = ~ack_p_i & ack_n_i;
  assign ack_bad_o = (ack_p_i == ack_n_i);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    unique case (st_q)
      PT_IDLE: begin
        if (trig_i || hold_i || pend_q) begin
          st_d   = PT_SEND;
          pend_d = 1'b0;
        end
      end
      PT_SEND: begin
        if (trig_i) pend_d = 1'b1;
        if (ack_hi) st_d = PT_DRAIN;
      end
      PT_DRAIN: begin
        if (trig_i) pend_d = 1'b1;
        if (ack_lo) begin
          if (pend_d || hold_i) begin
            st_d   = PT_SEND;
            pend_d = 1'b0;
          end else begin
            st_d = PT_IDLE;
          end
        end
      end
      default: begin
        st_d   = PT_IDLE;
        pend_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PT_IDLE;
      pend_q    <= 1'b0;
      alert_p_o <= 1'b0;
      alert_n_o <= 1'b1;
    end else begin
      st_q      <= st_d;
      pend_q    <= pend_d;
      alert_p_o <= (st_d == PT_SEND);
      alert_n_o <= (st_d != PT_SEND);
    end
  end
endmodule

// File: rtl/alert_cause_regs.sv
// Cause registers: recoverable bits are write-one-to-clear, fatal bits sticky.
module alert_cause_regs #(
  parameter int NUM_REC = 3,
  parameter int NUM_FAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REC-1:0] rec_err_i,
  input  logic [NUM_FAT-1:0] fat_err_i,
  input  logic               integ_i,
  input  logic               clr_wr_i,
  input  logic [NUM_REC-1:0] clr_bits_i,
  output logic [NUM_REC-1:0] rec_cause_o,
  output logic [NUM_FAT:0]   fat_cause_o
);
  logic [NUM_REC-1:0] clr_mask;
  assign clr_mask = clr_wr_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_cause_o <= '0;
      fat_cause_o <= '0;
    end else begin
      rec_cause_o <= (rec_cause_o & ~clr_mask) | rec_err_i;
      fat_cause_o <= fat_cause_o | {integ_i, fat_err_i};
    end
  end
endmodule

// File: rtl/err_alert_bundler.sv
module err_alert_bundler
  import alert_bndl_pkg::*;
#(
  parameter int NUM_REC = 3,
  parameter int NUM_FAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REC-1:0] rec_err_i,
  input  logic [NUM_FAT-1:0] fat_err_i,
  input  logic               test_wr_i,
  input  logic [1:0]         test_bits_i,
  input  logic               clr_wr_i,
  input  logic [NUM_REC-1:0] clr_bits_i,
  output logic [NUM_REC-1:0] rec_cause_o,
  output logic [NUM_FAT:0]   fat_cause_o,
  output logic               rec_alert_p_o,
  output logic               rec_alert_n_o,
  input  logic               rec_ack_p_i,
  input  logic               rec_ack_n_i,
  output logic               fat_alert_p_o,
  output logic               fat_alert_n_o,
  input  logic               fat_ack_p_i,
  input  logic               fat_ack_n_i
);
  logic [NUM_ALERTS-1:0] trig, hold, ack_p, ack_n, out_p, out_n, bad;
  logic [NUM_ALERTS-1:0] test_hit;
  logic rec_cond, rec_cond_q, fat_cond, fat_latch_q, integ;

  assign test_hit = test_wr_i ? test_bits_i : '0;
  assign integ    = |bad;
  assign rec_cond = |rec_err_i;
  assign fat_cond = (|fat_err_i) | integ | test_hit[ALERT_FAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_cond_q  <= 1'b0;
      fat_latch_q <= 1'b0;
    end else begin
      rec_cond_q  <= rec_cond;
      fat_latch_q <= fat_latch_q | fat_cond;
    end
  end

  assign trig[ALERT_REC] = (rec_cond & ~rec_cond_q) | test_hit[ALERT_REC];
  assign hold[ALERT_REC] = 1'b0;
  assign trig[ALERT_FAT] = 1'b0;
  assign hold[ALERT_FAT] = fat_latch_q;

  assign ack_p = {fat_ack_p_i, rec_ack_p_i};
  assign ack_n = {fat_ack_n_i, rec_ack_n_i};

  for (genvar g = 0; g < NUM_ALERTS; g++) begin : g_tx
    alert_pair_tx u_tx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig[g]),
      .hold_i    (hold[g]),
      .ack_p_i   (ack_p[g]),
      .ack_n_i   (ack_n[g]),
      .alert_p_o (out_p[g]),
      .alert_n_o (out_n[g]),
      .ack_bad_o (bad[g])
    );
  end

  assign rec_alert_p_o = out_p[ALERT_REC];
  assign rec_alert_n_o = out_n[ALERT_REC];
  assign fat_alert_p_o = out_p[ALERT_FAT];
  assign fat_alert_n_o = out_n[ALERT_FAT];

  alert_cause_regs #(.NUM_REC(NUM_REC), .NUM_FAT(NUM_FAT)) u_cause (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rec_err_i   (rec_err_i),
    .fat_err_i   (fat_err_i),
    .integ_i     (integ),
    .clr_wr_i    (clr_wr_i),
    .clr_bits_i  (clr_bits_i),
    .rec_cause_o (rec_cause_o),
    .fat_cause_o (fat_cause_o)
  );
endmodule

// File: rtl/err_alert_bundler_chk.sv
module err_alert_bundler_chk #(
  parameter int NUM_REC = 3,
  parameter int NUM_FAT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REC-1:0] rec_err_i,
  input logic [NUM_REC-1:0] rec_cause_o,
  input logic [NUM_FAT:0]   fat_cause_o,
  input logic               rec_alert_p_o,
  input logic               rec_ack_p_i,
  input logic               rec_ack_n_i,
  input logic               fat_alert_p_o,
  input logic               fat_ack_p_i,
  input logic               fat_ack_n_i
);
  // R2
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_alert_p_o && !(rec_ack_p_i && !rec_ack_n_i) |=> rec_alert_p_o);

  // R2
  fat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fat_alert_p_o && !(fat_ack_p_i && !fat_ack_n_i) |=> fat_alert_p_o);

  // R7
  rec_cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_i != '0 |=> (rec_cause_o & $past(rec_err_i)) == $past(rec_err_i));

  // R8
  fat_cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fat_cause_o != '0 |=> (fat_cause_o & $past(fat_cause_o)) == $past(fat_cause_o));

  // R9
  ack_integrity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_ack_p_i == rec_ack_n_i) || (fat_ack_p_i == fat_ack_n_i) |=> fat_cause_o[NUM_FAT]);
endmodule

bind err_alert_bundler err_alert_bundler_chk #(.NUM_REC(NUM_REC), .NUM_FAT(NUM_FAT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rec_err_i     (rec_err_i),
  .rec_cause_o   (rec_cause_o),
  .fat_cause_o   (fat_cause_o),
  .rec_alert_p_o (rec_alert_p_o),
  .rec_ack_p_i   (rec_ack_p_i),
  .rec_ack_n_i   (rec_ack_n_i),
  .fat_alert_p_o (fat_alert_p_o),
  .fat_ack_p_i   (fat_ack_p_i),
  .fat_ack_n_i   (fat_ack_n_i)
);

// File: tb/err_alert_bundler_test.sv
`timescale 1ns/1ps
module err_alert_bundler_test;
  localparam int NR = 3;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] rec_err = '0;
  logic [NF-1:0] fat_err = '0;
  logic test_wr = 1'b0;
  logic [1:0] test_bits = '0;
  logic clr_wr = 1'b0;
  logic [NR-1:0] clr_bits = '0;
  logic [NR-1:0] rec_cause;
  logic [NF:0] fat_cause;
  logic rec_p, rec_n, fat_p, fat_n;
  logic rsp_p [2];
  logic rsp_n [2];
  int   rsp_dly [2];
  logic corrupt = 1'b0;
  logic rec_ack_p, rec_ack_n;

  int n_chk = 0;
  int n_fail = 0;
  int fat_cnt = 0;
  string exp_rec[$];

  always #2.5 clk = ~clk;

  assign rec_ack_p = rsp_p[0] | corrupt;
  assign rec_ack_n = rsp_n[0] | corrupt;

  err_alert_bundler #(.NUM_REC(NR), .NUM_FAT(NF)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rec_err_i(rec_err), .fat_err_i(fat_err),
    .test_wr_i(test_wr), .test_bits_i(test_bits),
    .clr_wr_i(clr_wr), .clr_bits_i(clr_bits),
    .rec_cause_o(rec_cause), .fat_cause_o(fat_cause),
    .rec_alert_p_o(rec_p), .rec_alert_n_o(rec_n),
    .rec_ack_p_i(rec_ack_p), .rec_ack_n_i(rec_ack_n),
    .fat_alert_p_o(fat_p), .fat_alert_n_o(fat_n),
    .fat_ack_p_i(rsp_p[1]), .fat_ack_n_i(rsp_n[1])
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic alert_p(input int k);
    return (k == 0) ? rec_p : fat_p;
  endfunction

  // Handler model: answers each send after rsp_dly cycles (R2 handshake)
  task automatic responder(input int k);
    forever begin
      @(negedge clk);
      if (alert_p(k) === 1'b1 && rsp_p[k] == 1'b0) begin
        repeat (rsp_dly[k]) @(negedge clk);
        rsp_p[k] = 1'b1; rsp_n[k] = 1'b0;
        while (alert_p(k) === 1'b1) @(negedge clk);
        repeat (rsp_dly[k]) @(negedge clk);
        rsp_p[k] = 1'b0; rsp_n[k] = 1'b1;
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      rsp_p[k] = 1'b0; rsp_n[k] = 1'b1; rsp_dly[k] = 2;
    end
    fork
      responder(0);
      responder(1);
    join_none
  end

  // Monitor: every recoverable send must match a queued expectation
  initial begin
    logic rprev, fprev;
    rprev = 1'b0; fprev = 1'b0;
    forever begin
      @(negedge clk);
      if (rec_p === 1'b1 && !rprev) begin
        if (exp_rec.size() == 0) chk("R3 unexpected recoverable send", 1, 0);
        else chk(exp_rec.pop_front(), 1, 1);
      end
      if (fat_p === 1'b1 && !fprev) fat_cnt++;
      rprev = rec_p; fprev = fat_p;
    end
  end

  task automatic expect_rec(input string tag);
    exp_rec.push_back(tag);
  endtask

  task automatic drained(input string tag);
    chk({tag, " missing sends"}, exp_rec.size(), 0);
    exp_rec.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rec_err = '0; fat_err = '0; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 rec pair idle in reset", {rec_p, rec_n}, 2'b01);
    chk("R10 fat pair idle in reset", {fat_p, fat_n}, 2'b01);
    chk("R10 causes clear", {rec_cause, fat_cause}, '0);
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    fat_cnt = 0;
  endtask

  task automatic pulse_rec(input logic [NR-1:0] b);
    rec_err = b;
    @(negedge clk);
    rec_err = '0;
  endtask

  initial begin
    logic [NR-1:0] saved;
    repeat (3) @(negedge clk);
    chk("R1 rec pair idle after reset", {rec_p, rec_n}, 2'b01);
    chk("R1 fat pair idle after reset", {fat_p, fat_n}, 2'b01);
    chk("R1 causes zero", {rec_cause, fat_cause}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 single pulse
    expect_rec("R3 pulse send");
    pulse_rec(3'b010);
    repeat (40) @(negedge clk);
    drained("R3 pulse");

    // R3 held level gives one send
    expect_rec("R3 held send");
    rec_err = 3'b001;
    repeat (50) @(negedge clk);
    rec_err = '0;
    repeat (20) @(negedge clk);
    drained("R3 held");

    // R7 clearing
    chk("R7 causes set by sources", rec_cause, 3'b011);
    clr_wr = 1'b1; clr_bits = 3'b001;
    @(negedge clk);
    clr_wr = 1'b0;
    chk("R7 write-one clears bit0 only", rec_cause, 3'b010);
    expect_rec("R7 source2 send");
    rec_err = 3'b100;
    @(negedge clk);
    clr_wr = 1'b1; clr_bits = 3'b100;
    @(negedge clk);
    clr_wr = 1'b0;
    chk("R7 set wins over clear", rec_cause[2], 1'b1);
    rec_err = '0;
    clr_wr = 1'b1; clr_bits = 3'b110;
    @(negedge clk);
    clr_wr = 1'b0;
    chk("R7 clear after source drops", rec_cause, 3'b000);
    repeat (30) @(negedge clk);
    drained("R7");

    // R2 hold until acknowledged
    rsp_dly[0] = 8;
    expect_rec("R2 send");
    pulse_rec(3'b001);
    repeat (4) @(negedge clk);
    chk("R2 pair held while unacked", {rec_p, rec_n}, 2'b10);
    repeat (40) @(negedge clk);
    chk("R2 pair idle after handshake", {rec_p, rec_n}, 2'b01);
    drained("R2");

    // R4 merging of triggers during a handshake
    rsp_dly[0] = 6;
    expect_rec("R4 first send");
    expect_rec("R4 merged pending send");
    pulse_rec(3'b001);
    repeat (2) @(negedge clk);
    pulse_rec(3'b010);
    repeat (2) @(negedge clk);
    pulse_rec(3'b100);
    repeat (60) @(negedge clk);
    drained("R4");
    rsp_dly[0] = 2;

    // R6 recoverable test injection
    clr_wr = 1'b1; clr_bits = '1;
    @(negedge clk);
    clr_wr = 1'b0;
    saved = rec_cause;
    expect_rec("R6 test send");
    test_wr = 1'b1; test_bits = 2'b01;
    @(negedge clk);
    test_wr = 1'b0; test_bits = '0;
    repeat (30) @(negedge clk);
    drained("R6");
    chk("R6 test leaves rec cause", rec_cause, saved);
    chk("R6 rec test leaves fatal idle", fat_cnt, 0);

    // R5 / R8 fatal latching
    fat_err = 2'b01;
    @(negedge clk);
    fat_err = '0;
    repeat (100) @(negedge clk);
    chk("R5 fatal repeats after source drops", fat_cnt >= 3, 1'b1);
    chk("R8 fatal cause bit0", fat_cause, 3'b001);
    clr_wr = 1'b1; clr_bits = '1;
    @(negedge clk);
    clr_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 clear write ignored by fatal causes", fat_cause, 3'b001);

    // R10 reset stops the fatal stream
    do_reset();
    repeat (30) @(negedge clk);
    chk("R10 no fatal sends after reset", fat_cnt, 0);

    // R6 fatal test injection
    test_wr = 1'b1; test_bits = 2'b10;
    @(negedge clk);
    test_wr = 1'b0; test_bits = '0;
    repeat (60) @(negedge clk);
    chk("R6 fatal test repeats", fat_cnt >= 3, 1'b1);
    chk("R6 fatal test sets no cause", fat_cause, 3'b000);
    do_reset();

    // R9 acknowledge integrity fault
    corrupt = 1'b1;
    @(negedge clk);
    corrupt = 1'b0;
    chk("R9 integrity cause bit", fat_cause, 3'b100);
    repeat (60) @(negedge clk);
    chk("R9 fatal alert raised", fat_cnt >= 3, 1'b1);
    do_reset();
    drained("final");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule